// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block lets a clocked system read and write an external asynchronous static memory of 8192 bytes. The user side gives one request at a time: a valid strobe with an address, a write flag and write data, accepted in any cycle where the ready output is high. A read returns its data with a single-cycle response pulse. A write completes when ready comes back high.

On the memory side the block drives a 13-bit address and two chip selects of opposite polarity: one is active low and the other active high. It also drives an active-low write strobe and an active-low read (output) strobe. The 8-bit data bus appears as a separate output value, input value and drive enable, so that a pad-level tristate buffer can be placed at the chip edge.

Every access is sequenced over a parameterised number of clock cycles. This lets the access time of any memory speed grade be met at the chosen clock period.

All memory-side pins come straight from flops. A write is framed by both selects and the write strobe. The write strobe rises first, and the address, data and selects stay unchanged across that edge. When the access direction changes, idle turnaround cycles separate the memory's output drive from the controller's drive. Between accesses the memory is deselected so that it powers down.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, ready is high, the active-low select is high, the active-high select is low, both strobes are high, the bus drive enable is low and the response pulse is low.
- R2: Whenever ready is high, the memory is deselected (active-low select high, active-high select low), both strobes are high and the bus drive enable is low.
- R3: The write strobe is low only while both selects are active, the read strobe is high and the bus drive enable is high.
- R4: The write strobe falls exactly one cycle after the address, both selects and the bus drive have settled, and stays low for exactly WR_PULSE cycles.
- R5: When the write strobe rises, both selects are still active, the drive enable is still high, and the address and write data are unchanged from the previous cycle. The selects and drive release one cycle later.
- R6: The read strobe is low only while both selects are active and the write strobe is high. The response pulse rises RD_WAIT clock edges after the edge that entered the read phase.
- R7: The bus drive enable is never high while the read strobe is low.
- R8: Read data returned with the response pulse equals the byte most recently written to that address.
- R9: The response pulse lasts exactly one cycle and occurs only for reads. A write keeps ready low for WR_PULSE+2 cycles after the accepting edge, plus turnaround.
- R10: When an access has the opposite direction to the previous one (the direction after reset counts as read), TURN cycles are inserted before it. At least TURN+1 cycles with both strobes high and drive off separate read drive from write drive.
- R11: Consecutive accesses in the same direction get no turnaround. A read's response pulse is visible RD_WAIT+1 sampling points after its accepting edge, and a write's ready returns at WR_PULSE+3.
- R12: A request strobe raised while ready is low is ignored: it starts no access and changes no memory content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | DW | Read data |
| mem_addr | output | AW | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output (read) strobe |
| mem_dq_o | output | DW | Data value to drive onto the bus |
| mem_dq_i | input | DW | Data value seen on the bus |
| mem_dq_oe | output | 1 | Bus drive enable for the external tristate buffer |

## Verification
The assertions assume that the memory-side input settles within RD_WAIT cycles of the read strobe falling. They also assume that the user holds each request word steady only while it is being accepted, because the block latches the address and data on acceptance. The bench's memory model updates its read data half a cycle after the pins change. It stores a byte on the rising write strobe only when both selects and the drive are active. Requests are raised only at falling edges and are dropped after one cycle, with one exception: a deliberate request during a busy write, which checks that such requests are ignored.

// File: rtl/sac_pkg.sv
package sac_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_TURN = 3'd1,
      ST_RD   = 3'd2,
      ST_WSET = 3'd3,
      ST_WPUL = 3'd4,
      ST_WHLD = 3'd5
   } sac_state_e;

   function automatic int sac_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sac_wait_cnt.sv
module sac_wait_cnt #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // R4/R6 windows rely on the counter resting at zero until reloaded
   p_cnt_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |=> done);

endmodule

// File: rtl/sac_seq.sv
module sac_seq
   import sac_pkg::*;
#(
   parameter int RD_WAIT  = 3,
   parameter int WR_PULSE = 2,
   parameter int TURN     = 1,
   parameter int CW       = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          cnt_done,
   output sac_state_e    state_q,
   output sac_state_e    state_d,
   output logic          cnt_load,
   output logic [CW-1:0] cnt_val,
   output logic          accept,
   output logic          capture
);

   localparam logic [CW-1:0] RD_LD   = CW'(RD_WAIT - 1);
   localparam logic [CW-1:0] WR_LD   = CW'(WR_PULSE - 1);
   localparam logic [CW-1:0] TURN_LD = CW'(TURN - 1);

   logic dir_wr_q;

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               if (req_write != dir_wr_q) begin
                  state_d  = ST_TURN;
                  cnt_load = 1'b1;
                  cnt_val  = TURN_LD;
               end else if (req_write) begin
                  state_d = ST_WSET;
               end else begin
                  state_d  = ST_RD;
                  cnt_load = 1'b1;
                  cnt_val  = RD_LD;
               end
            end
         end
         ST_TURN: begin
            if (cnt_done) begin
               if (dir_wr_q) begin
                  state_d = ST_WSET;
               end else begin
                  state_d  = ST_RD;
                  cnt_load = 1'b1;
                  cnt_val  = RD_LD;
               end
            end
         end
         ST_RD: begin
            if (cnt_done) begin
               capture = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_WSET: begin
            state_d  = ST_WPUL;
            cnt_load = 1'b1;
            cnt_val  = WR_LD;
         end
         ST_WPUL: begin
            if (cnt_done) state_d = ST_WHLD;
         end
         ST_WHLD: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         dir_wr_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) dir_wr_q <= req_write;
      end
   end

endmodule

// File: rtl/sac_pins.sv
module sac_pins
   import sac_pkg::*;
#(
   parameter int AW        = 13,
   parameter int DW        = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sac_state_e    state_d,
   input  logic          accept,
   input  logic          capture,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] mem_dq_i,
   output logic [AW-1:0] mem_addr,
   output logic          mem_sel_n,
   output logic          mem_sel,
   output logic          mem_wr_n,
   output logic          mem_rd_n,
   output logic [DW-1:0] mem_dq_o,
   output logic          mem_dq_oe,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);

   logic          sel_d, wr_d, rd_d, oe_d;
   logic [DW-1:0] wdata_q;

   always_comb begin
      sel_d = (state_d == ST_RD)   || (state_d == ST_WSET) ||
              (state_d == ST_WPUL) || (state_d == ST_WHLD);
      wr_d  = (state_d == ST_WPUL);
      rd_d  = (state_d == ST_RD);
      oe_d  = (state_d == ST_WSET) || (state_d == ST_WPUL) || (state_d == ST_WHLD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_sel_n <= 1'b1;
         mem_sel   <= 1'b0;
         mem_wr_n  <= 1'b1;
         mem_rd_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
         mem_addr  <= '0;
         wdata_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         mem_sel_n <= !sel_d;
         mem_sel   <= sel_d;
         mem_wr_n  <= !wr_d;
         mem_rd_n  <= !rd_d;
         mem_dq_oe <= oe_d;
         if (accept) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
         end
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_i;
      end
   end

   generate
      if (PARK_ZERO) begin : g_park
         assign mem_dq_o = mem_dq_oe ? wdata_q : '0;
      end else begin : g_hold
         assign mem_dq_o = wdata_q;
      end
   endgenerate

   p_wr_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_rd_n && mem_dq_oe));

   p_wr_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr_n) |-> $past(!mem_sel_n && mem_sel && mem_dq_oe && mem_wr_n));

   p_wr_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n) |-> (!mem_sel_n && mem_sel && mem_dq_oe &&
                           $stable(mem_addr) && $stable(mem_dq_o)));

   p_wr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n) |=> (mem_sel_n && !mem_sel && !mem_dq_oe));

   p_rd_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd_n |-> (!mem_sel_n && mem_sel && mem_wr_n));

   p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_rd_n);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sac_pkg::*;
#(
   parameter int AW        = 13,
   parameter int DW        = 8,
   parameter int RD_WAIT   = 3,
   parameter int WR_PULSE  = 2,
   parameter int TURN      = 1,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_sel_n,
   output logic          mem_sel,
   output logic          mem_wr_n,
   output logic          mem_rd_n,
   output logic [DW-1:0] mem_dq_o,
   input  logic [DW-1:0] mem_dq_i,
   output logic          mem_dq_oe
);

   localparam int MAXW = sac_max3(RD_WAIT, WR_PULSE, TURN);
   localparam int CW   = $clog2(MAXW) + 1;

   initial begin
      assert (AW >= 1)       else $error("AW must be at least 1");
      assert (DW >= 1)       else $error("DW must be at least 1");
      assert (RD_WAIT >= 1)  else $error("RD_WAIT must be at least 1");
      assert (WR_PULSE >= 1) else $error("WR_PULSE must be at least 1");
      assert (TURN >= 1)     else $error("TURN must be at least 1");
   end

   sac_state_e    state_q, state_d;
   logic          cnt_load, cnt_done, accept, capture;
   logic [CW-1:0] cnt_val;

   sac_seq #(
      .RD_WAIT (RD_WAIT),
      .WR_PULSE(WR_PULSE),
      .TURN    (TURN),
      .CW      (CW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .cnt_done (cnt_done),
      .state_q  (state_q),
      .state_d  (state_d),
      .cnt_load (cnt_load),
      .cnt_val  (cnt_val),
      .accept   (accept),
      .capture  (capture)
   );

   sac_wait_cnt #(.CW(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cnt_load),
      .load_val(cnt_val),
      .done    (cnt_done)
   );

   sac_pins #(
      .AW       (AW),
      .DW       (DW),
      .PARK_ZERO(PARK_ZERO)
   ) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_d  (state_d),
      .accept   (accept),
      .capture  (capture),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .mem_dq_i (mem_dq_i),
      .mem_addr (mem_addr),
      .mem_sel_n(mem_sel_n),
      .mem_sel  (mem_sel),
      .mem_wr_n (mem_wr_n),
      .mem_rd_n (mem_rd_n),
      .mem_dq_o (mem_dq_o),
      .mem_dq_oe(mem_dq_oe),
      .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata)
   );

   assign req_ready = (state_q == ST_IDLE);

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe));

   p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_rsp_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_rd_n));

   p_turn_w2r_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_rd_n) |-> $past(!mem_dq_oe));

   p_turn_r2w_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> $past(mem_rd_n));

   p_busy_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> $stable(mem_addr));

endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/100ps
module sim_sram_async_ctrl;

   localparam int AW = 13, DW = 8;
   localparam int RD_WAIT = 3, WR_PULSE = 2, TURN = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_o;
   logic [DW-1:0] mem_dq_i = '0;

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sram_async_ctrl #(
      .AW(AW), .DW(DW), .RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE), .TURN(TURN), .PARK_ZERO(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
      .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
   );

   // memory model
   logic [DW-1:0] mem_m [int];

   always @(posedge mem_wr_n) begin
      if (rst_n === 1'b1 && mem_sel_n === 1'b0 && mem_sel === 1'b1 && mem_dq_oe === 1'b1)
         mem_m[int'(mem_addr)] = mem_dq_o;
   end

   always @(negedge clk) begin
      if (!mem_sel_n && mem_sel && !mem_rd_n && mem_wr_n)
         mem_dq_i <= mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00;
      else
         mem_dq_i <= 8'h00;
   end

   // pin monitor
   int viol = 0, r5_bad = 0;
   int since_oe = 100, since_rd = 100, gap_w2r = 0, gap_r2w = 0;
   int pulse_cnt = 0, last_pulse = 0;
   logic prev_rd = 1'b1, prev_wr = 1'b1, prev_oe = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] prev_dq = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if ((!mem_wr_n && (mem_sel_n || !mem_sel || !mem_dq_oe)) ||
             (mem_dq_oe && !mem_rd_n) || (!mem_rd_n && !mem_wr_n)) viol++;
         if (!mem_rd_n && prev_rd) gap_w2r = since_oe;
         if (mem_dq_oe && !prev_oe) gap_r2w = since_rd;
         since_oe = mem_dq_oe ? 0 : since_oe + 1;
         since_rd = !mem_rd_n ? 0 : since_rd + 1;
         if (!mem_wr_n) pulse_cnt++;
         else if (!prev_wr) begin
            last_pulse = pulse_cnt;
            pulse_cnt  = 0;
            if (mem_sel_n || !mem_sel || !mem_dq_oe ||
                mem_addr != prev_addr || mem_dq_o != prev_dq) r5_bad++;
         end
         prev_rd = mem_rd_n; prev_wr = mem_wr_n; prev_oe = mem_dq_oe;
         prev_addr = mem_addr; prev_dq = mem_dq_o;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat, output logic [DW-1:0] rd, output bit saw_rsp);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1; saw_rsp = 1'b0; rd = '0;
      if (wr) begin
         while (!req_ready) begin
            if (rsp_valid) saw_rsp = 1'b1;
            @(negedge clk); lat++;
         end
         if (rsp_valid) saw_rsp = 1'b1;
      end else begin
         while (!rsp_valid) begin @(negedge clk); lat++; end
         saw_rsp = 1'b1; rd = rsp_rdata;
         @(negedge clk);
         chk(!rsp_valid, "R9 pulse width", int'(rsp_valid), 0);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(req_ready && mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe && !rsp_valid,
          "R1 reset pins", {req_ready, mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe, rsp_valid},
          7'b1101100);
      rst_n = 1'b1;
   endtask

   task automatic t_writes();
      int lat; logic [DW-1:0] rd; bit s;
      do_req(1'b1, 13'h0012, 8'hA5, lat, rd, s);
      chk(lat == WR_PULSE + 3 + TURN, "R10 first write turnaround latency", lat, WR_PULSE + 3 + TURN);
      chk(last_pulse == WR_PULSE, "R4 write pulse width", last_pulse, WR_PULSE);
      chk(!s, "R9 no response for write", int'(s), 0);
      do_req(1'b1, 13'h1FFF, 8'h5A, lat, rd, s);
      chk(lat == WR_PULSE + 3, "R11 same-direction write latency", lat, WR_PULSE + 3);
      do_req(1'b1, 13'h0000, 8'hC3, lat, rd, s);
      chk(lat == WR_PULSE + 3, "R9 write busy span", lat, WR_PULSE + 3);
   endtask

   task automatic t_reads();
      int lat; logic [DW-1:0] rd; bit s;
      do_req(1'b0, 13'h0012, 8'h00, lat, rd, s);
      chk(lat == RD_WAIT + 1 + TURN, "R6 read latency after write", lat, RD_WAIT + 1 + TURN);
      chk(rd == 8'hA5, "R8 read data 0x0012", int'(rd), 8'hA5);
      chk(gap_w2r >= TURN + 1, "R10 write-to-read gap", gap_w2r, TURN + 1);
      do_req(1'b0, 13'h1FFF, 8'h00, lat, rd, s);
      chk(lat == RD_WAIT + 1, "R11 back-to-back read latency", lat, RD_WAIT + 1);
      chk(rd == 8'h5A, "R8 read data top address", int'(rd), 8'h5A);
      do_req(1'b0, 13'h0000, 8'h00, lat, rd, s);
      chk(rd == 8'hC3, "R8 read data address zero", int'(rd), 8'hC3);
   endtask

   task automatic t_r2w();
      int lat; logic [DW-1:0] rd; bit s;
      do_req(1'b1, 13'h0AAA, 8'h11, lat, rd, s);
      chk(lat == WR_PULSE + 3 + TURN, "R10 read-to-write latency", lat, WR_PULSE + 3 + TURN);
      chk(gap_r2w >= TURN + 1, "R10 read-to-write gap", gap_r2w, TURN + 1);
      @(negedge clk);
      chk(req_ready && mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe,
          "R2 idle deselected", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe}, 5'b10110);
   endtask

   task automatic t_busy();
      int lat; logic [DW-1:0] rd; bit s;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0555; req_wdata = 8'h3C;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0AAA; req_wdata = 8'hFF;
      chk(!req_ready, "R12 busy during write", int'(req_ready), 0);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
      do_req(1'b0, 13'h0AAA, 8'h00, lat, rd, s);
      chk(rd == 8'h11, "R12 busy request ignored", int'(rd), 8'h11);
      do_req(1'b0, 13'h0555, 8'h00, lat, rd, s);
      chk(rd == 8'h3C, "R8 read data after busy", int'(rd), 8'h3C);
   endtask

   initial begin
      t_reset();
      t_writes();
      t_reads();
      t_r2w();
      t_busy();
      chk(viol == 0, "R3 R7 strobe framing violations", viol, 0);
      chk(r5_bad == 0, "R5 write end hold", r5_bad, 0);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule